// File: doc/BRIEF.md
# Vernier Count Capture and Serial Readout

This block turns the race between two ring oscillators of slightly different frequency into a number. While the mode input selects write, it counts the cycles of the slower oscillator, which also serves as its clock, for as long as the phase-detector flag stays low. The first rising edge of that flag means the faster oscillator has overtaken the slower one. At that edge the count freezes and the counter disarms. Any later activity on the flag is ignored until write mode is entered again. Entering write mode clears the count and its overflow flag and arms the counter for the next hit.

When the mode input switches to read, the oscillator domain copies the frozen count and its overflow flag into a shadow register. The read domain runs on its own slow read clock. It sees the mode change through a two-flop synchroniser and only then loads the shadow value into a shift register. It sends the value out one bit per accepted transfer over a valid/ready stream, so few pads are needed. The frame ends after the last bit. Returning to write mode aborts a frame that has not finished. The read clock period must be longer than three oscillator periods, so that the shadow register is settled before the read domain samples it.

Stream rules: `ser_valid` high means `ser_data` holds the current bit, and a bit is transferred on a rising edge of `rd_clk` where both `ser_valid` and `ser_ready` are high. While `ser_ready` is low, `ser_valid` and `ser_data` hold their values. Once a frame has started, `ser_valid` does not wait for `ser_ready`.

Top module: `vcap_readout`

## Requirements
- R1: After reset `ser_valid` and `ser_data` are low, and the count and overflow flag are zero, so a read before any oscillator activity returns all zeros.
- R2: In write mode the count equals the number of rising `osc_clk` edges at which `pd_flag` was low, counted from write-mode entry up to the first rising edge of `pd_flag`.
- R3: After a rising edge of `pd_flag`, later low periods of `pd_flag` do not change the count until write mode is entered again.
- R4: The count saturates at 2^CNT_W-1 (255 by default). A counting edge that arrives while the count is at that maximum sets the overflow flag, and exactly 255 counting edges leave the flag clear.
- R5: A change of `rd_mode` from 1 to 0 (entering write mode) clears the count and the overflow flag and rearms the counter.
- R6: A change of `rd_mode` from 0 to 1 starts one frame of CNT_W+1 transfers: the count bits from the most significant downwards, then the overflow flag. `ser_valid` is high for exactly those transfers, and `ser_data` is low whenever `ser_valid` is low.
- R7: While `ser_valid` is high and `ser_ready` is low, `ser_valid` stays high and `ser_data` keeps its value.
- R8: Setting `rd_mode` to 0 during a frame ends it: `ser_valid` goes low within three `rd_clk` edges and stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Clock from the slower vernier oscillator |
| rd_clk | input | 1 | Slow read clock for serial output |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rd_mode | input | 1 | Mode: 0 selects write (count), 1 selects read (shift out) |
| pd_flag | input | 1 | Phase-detector flag, goes high when the fast oscillator catches up |
| ser_ready | input | 1 | Sink accepts the current bit |
| ser_valid | output | 1 | High for each bit of a frame |
| ser_data | output | 1 | Current serial bit |

## Verification
The bench builds the block with its default 8-bit count and 2-stage synchronisers. With this width it can drive the counter all the way to saturation with 255 and 300 counting edges, so the edge where the overflow flag is set lies in reach. The oscillator clock is eight times faster than the read clock. This spacing lets the bench exercise stalls in the middle of a frame, an abort after three bits, and the ordering of the shadow transfer between the two domains.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
  typedef enum logic {
    MODE_WRITE = 1'b0,
    MODE_READ  = 1'b1
  } vcap_mode_e;

  function automatic int frame_len(input int cnt_w);
    return cnt_w + 1;
  endfunction
endpackage

// File: rtl/vcap_sync.sv
module vcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= '0;
        else        ff <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= '0;
        else        ff <= {ff[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/vcap_counter.sv
module vcap_counter
  import vcap_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic           osc_clk,
  input  logic           rst_n,
  input  logic           mode_s,
  input  logic           pd_flag,
  output logic [CNT_W:0] shadow
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic             ovf;
  logic             armed;
  logic             pd_q;
  logic             mode_q;
  logic             wr_entry;
  logic             rd_entry;
  logic             pd_rise;
  logic             cnt_en;

  assign wr_entry = mode_q && (mode_s == MODE_WRITE);
  assign rd_entry = !mode_q && (mode_s == MODE_READ);
  assign pd_rise  = pd_flag && !pd_q;
  assign cnt_en   = !wr_entry && armed && !pd_flag && (mode_s == MODE_WRITE);

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      pd_q   <= 1'b1;
    end else begin
      mode_q <= mode_s;
      pd_q   <= pd_flag;
    end
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ovf   <= 1'b0;
      armed <= 1'b1;
    end else if (wr_entry) begin
      cnt   <= '0;
      ovf   <= 1'b0;
      armed <= 1'b1;
    end else if (armed && pd_rise) begin
      armed <= 1'b0;
    end else if (cnt_en) begin
      if (cnt == CNT_MAX) ovf <= 1'b1;
      else                cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n)        shadow <= '0;
    else if (rd_entry) shadow <= {cnt, ovf};
  end

  a_r2_increment: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (cnt_en && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

  a_r3_frozen: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (!armed && !wr_entry) |=> ($stable(cnt) && $stable(ovf)));

  a_r4_saturate: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !wr_entry) |=> (cnt == CNT_MAX));

  a_r4_ovf_sticky: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (ovf && !wr_entry) |=> ovf);

  a_r5_clear: assert property (@(posedge osc_clk) disable iff (!rst_n)
    wr_entry |=> (cnt == '0 && !ovf && armed));
endmodule

// File: rtl/vcap_serializer.sv
module vcap_serializer #(
  parameter int FRAME_W = 9
) (
  input  logic               rd_clk,
  input  logic               rst_n,
  input  logic               mode_s,
  input  logic [FRAME_W-1:0] shadow,
  input  logic               ser_ready,
  output logic               ser_valid,
  output logic               ser_data
);
  localparam int LEFT_W = $clog2(FRAME_W + 1);
  localparam logic [LEFT_W-1:0] LEFT_INIT = LEFT_W'(FRAME_W);

  logic [FRAME_W-1:0] shreg;
  logic [LEFT_W-1:0]  left;
  logic               mode_q;
  logic               start;
  logic               xfer;

  assign start = mode_s && !mode_q;
  assign xfer  = ser_valid && ser_ready;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_s;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      left      <= '0;
      ser_valid <= 1'b0;
    end else if (!mode_s) begin
      left      <= '0;
      ser_valid <= 1'b0;
    end else if (start) begin
      shreg     <= shadow;
      left      <= LEFT_INIT;
      ser_valid <= 1'b1;
    end else if (xfer) begin
      shreg <= shreg << 1;
      left  <= left - 1'b1;
      if (left == LEFT_W'(1)) ser_valid <= 1'b0;
    end
  end

  assign ser_data = ser_valid && shreg[FRAME_W-1];

  a_r7_hold: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (ser_valid && !ser_ready && mode_s) |=> (ser_valid && $stable(ser_data)));

  a_r6_length: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (left <= LEFT_INIT) && (ser_valid == (left != '0)));

  a_r8_abort: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !mode_s |=> !ser_valid);
endmodule

// File: rtl/vcap_readout.sv
module vcap_readout
  import vcap_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic osc_clk,
  input  logic rd_clk,
  input  logic rst_n,
  input  logic rd_mode,
  input  logic pd_flag,
  input  logic ser_ready,
  output logic ser_valid,
  output logic ser_data
);
  localparam int FRAME_W = frame_len(CNT_W);

  logic               mode_osc;
  logic               mode_rd;
  logic [FRAME_W-1:0] shadow;

  vcap_sync #(.STAGES(SYNC_STAGES)) u_sync_osc (
    .clk(osc_clk), .rst_n(rst_n), .d(rd_mode), .q(mode_osc)
  );

  vcap_sync #(.STAGES(SYNC_STAGES)) u_sync_rd (
    .clk(rd_clk), .rst_n(rst_n), .d(rd_mode), .q(mode_rd)
  );

  vcap_counter #(.CNT_W(CNT_W)) u_counter (
    .osc_clk(osc_clk), .rst_n(rst_n), .mode_s(mode_osc),
    .pd_flag(pd_flag), .shadow(shadow)
  );

  vcap_serializer #(.FRAME_W(FRAME_W)) u_ser (
    .rd_clk(rd_clk), .rst_n(rst_n), .mode_s(mode_rd), .shadow(shadow),
    .ser_ready(ser_ready), .ser_valid(ser_valid), .ser_data(ser_data)
  );
endmodule

// File: tb/test_vcap_readout.sv
module test_vcap_readout;
  logic osc_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_mode = 1'b0;
  logic pd_flag = 1'b1;
  logic ser_ready = 1'b1;
  logic ser_valid;
  logic ser_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 osc_clk = ~osc_clk;
  always #20 rd_clk = ~rd_clk;

  vcap_readout i_vcap_readout (
    .osc_clk(osc_clk), .rd_clk(rd_clk), .rst_n(rst_n), .rd_mode(rd_mode),
    .pd_flag(pd_flag), .ser_ready(ser_ready), .ser_valid(ser_valid),
    .ser_data(ser_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Enter write mode, then hold pd_flag low for n counting edges, then
  // optionally drop it again for 'extra' edges after the catch-up.
  task automatic do_write(input int n, input int extra);
    @(negedge osc_clk);
    pd_flag = 1'b1;
    rd_mode = 1'b0;
    repeat (8) @(negedge osc_clk);
    pd_flag = 1'b0;
    repeat (n) @(negedge osc_clk);
    pd_flag = 1'b1;
    repeat (3) @(negedge osc_clk);
    if (extra > 0) begin
      pd_flag = 1'b0;
      repeat (extra) @(negedge osc_clk);
      pd_flag = 1'b1;
      repeat (3) @(negedge osc_clk);
    end
  endtask

  // Enter read mode and collect a frame; stall for three cycles before
  // transfer index stall_at (negative: no stall).
  task automatic do_read(input int stall_at, input string req,
                         output logic [8:0] bits, output int nbits);
    int w;
    logic d0;
    @(negedge rd_clk);
    ser_ready = 1'b1;
    rd_mode = 1'b1;
    w = 0;
    while (!ser_valid && w < 20) begin
      @(negedge rd_clk);
      w++;
    end
    nbits = 0;
    bits = '0;
    while (ser_valid && nbits < 12) begin
      if (nbits == stall_at) begin
        ser_ready = 1'b0;
        d0 = ser_data;
        for (int k = 0; k < 3; k++) begin
          @(negedge rd_clk);
          chk(ser_valid && ser_data == d0, "R7 hold under stall",
              int'(ser_data), int'(d0));
        end
        ser_ready = 1'b1;
      end
      bits = {bits[7:0], ser_data};
      nbits++;
      @(negedge rd_clk);
    end
    chk(nbits == 9, {req, " R6 frame length"}, nbits, 9);
    chk(!ser_data, "R6 data low outside frame", int'(ser_data), 0);
    repeat (2) @(negedge rd_clk);
    chk(!ser_valid, "R6 no second frame", int'(ser_valid), 0);
  endtask

  task automatic t_count(input int n, input int extra, input int stall_at,
                         input string req);
    logic [8:0] bits;
    int nb;
    int ec;
    int eo;
    ec = (n > 255) ? 255 : n;
    eo = (n > 255) ? 1 : 0;
    do_write(n, extra);
    do_read(stall_at, req, bits, nb);
    chk(int'(bits[8:1]) == ec, {req, " count"}, int'(bits[8:1]), ec);
    chk(int'(bits[0]) == eo, {req, " overflow"}, int'(bits[0]), eo);
  endtask

  task automatic t_reset();
    logic [8:0] bits;
    int nb;
    chk(!ser_valid, "R1 valid after reset", int'(ser_valid), 0);
    chk(!ser_data, "R1 data after reset", int'(ser_data), 0);
    do_read(-1, "R1", bits, nb);
    chk(bits == 9'd0, "R1 read after reset", int'(bits), 0);
  endtask

  task automatic t_abort();
    int seen;
    @(negedge osc_clk);
    rd_mode = 1'b0;
    repeat (10) @(negedge osc_clk);
    @(negedge rd_clk);
    ser_ready = 1'b1;
    rd_mode = 1'b1;
    seen = 0;
    while (!ser_valid && seen < 20) begin
      @(negedge rd_clk);
      seen++;
    end
    repeat (3) @(negedge rd_clk);
    chk(ser_valid, "R8 frame running before abort", int'(ser_valid), 1);
    rd_mode = 1'b0;
    repeat (4) @(negedge rd_clk);
    chk(!ser_valid, "R8 valid dropped after abort", int'(ser_valid), 0);
    repeat (10) @(negedge rd_clk);
    chk(!ser_valid && !ser_data, "R8 stays idle", int'(ser_valid), 0);
  endtask

  initial begin
    repeat (5) @(negedge rd_clk);
    rst_n = 1'b1;
    repeat (2) @(negedge rd_clk);
    t_reset();
    t_count(5, 0, -1, "R2 small");
    t_count(200, 0, -1, "R2 large");
    t_count(9, 12, -1, "R3 ignore after catch-up");
    t_count(255, 0, -1, "R4 exact max");
    t_count(300, 0, -1, "R4 saturated");
    t_count(3, 0, -1, "R5 cleared after saturation");
    t_count(0, 0, -1, "R5 zero after rearm");
    t_count(165, 0, 4, "R7 stalled frame");
    t_count(170, 0, 0, "R7 stall first bit");
    t_abort();
    t_count(2, 0, -1, "R8 frame after abort");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule